// File: doc/BRIEF.md
# Column Command Turnaround Scheduler

This block sits inside a memory controller, between the queue of pending column accesses and the command bus of a DRAM device. Every access is a page hit, so the only decision left is the cycle in which each read or write column command may go out. The block enforces the minimum spacing between column commands of the same kind. It also enforces the turnaround between a write and a following read, and between a read and a following write. Each spacing applies whichever bank the commands target.

For every accepted command the block schedules the matching data-bus event. A write raises a strobe in the cycle the controller must launch write data. A read raises a strobe in the cycle read data arrives. Several commands may be in flight at once. All timing values are static inputs in clock cycles and may change only while the block is idle.

Each turnaround is the largest of three values: the programmed figure, the column spacing, and a figure derived from the two data latencies and the required idle gap on the data bus. This means a programmed value that is too small can never make read and write data collide.

Top module: `col_sched`

## Requirements
- R1: After reset, `req_ready` is high for either command type and neither data strobe is high until a command has been issued.
- R2: A read issues no earlier than G_WR cycles after the most recent write, where G_WR = max(`cfg_wr_rd`, `cfg_wr_bub` + `cfg_cc` + `cfg_wr_lat` − `cfg_rd_lat`, `cfg_cc`).
- R3: A write issues no earlier than G_RW cycles after the most recent read, where G_RW = max(`cfg_rd_wr`, `cfg_rd_lat` − `cfg_wr_lat` + `cfg_cc` + `cfg_rd_bub`, `cfg_cc`).
- R4: Two commands of the same type are at least `cfg_cc` cycles apart.
- R5: `wdata_launch` is high for one cycle exactly `cfg_wr_lat` cycles after each write issue (`cfg_wr_lat` in 1..DLY_MAX). Any number of writes may be outstanding.
- R6: `rdata_valid` is high for one cycle exactly `cfg_rd_lat` cycles after each read issue (`cfg_rd_lat` in 1..DLY_MAX). Any number of reads may be outstanding.
- R7: A command issues in the cycle where `req_valid` and `req_ready` are both high. In that same cycle `iss_valid` is high, `iss_wr` carries the type (1 = write, 0 = read) and `iss_bank` carries `req_bank`.
- R8: `req_ready` reflects the type on `req_wr`. It is high in exactly those cycles where every spacing that applies to that type (R2, R3, R4) has elapsed, with no extra stall cycle.
- R9: The bank number has no effect on any spacing: a read to another bank after a write still waits exactly G_WR when presented back to back.
- R10: Treat each data packet as `cfg_cc` cycles long. Then a read packet starts at least `cfg_wr_bub` idle cycles after the preceding write packet ends. A write packet starts at least `cfg_rd_bub` idle cycles after the preceding read packet ends. Packets in the same direction never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cc | input | TW | Minimum spacing of column commands, cycles (>= 1) |
| cfg_wr_rd | input | TW | Programmed write-to-read turnaround |
| cfg_rd_wr | input | TW | Programmed read-to-write turnaround |
| cfg_wr_lat | input | TW | Command-to-write-data delay (1..DLY_MAX) |
| cfg_rd_lat | input | TW | Command-to-read-data delay (1..DLY_MAX) |
| cfg_wr_bub | input | TW | Minimum data-bus idle gap from write data to read data |
| cfg_rd_bub | input | TW | Minimum data-bus idle gap from read data to write data |
| req_valid | input | 1 | A column request is presented |
| req_wr | input | 1 | Request type: 1 write, 0 read |
| req_bank | input | BANK_W | Target bank of the request |
| req_ready | output | 1 | Request may issue this cycle |
| iss_valid | output | 1 | A column command issues this cycle |
| iss_wr | output | 1 | Type of the issued command |
| iss_bank | output | BANK_W | Bank of the issued command |
| wdata_launch | output | 1 | Drive write data this cycle |
| rdata_valid | output | 1 | Read data arrives this cycle |

## Verification
Two directed streams run with the request held valid: write-write-read on different banks, and read-read-write. The first tells the column spacing apart from the cross-bank write-to-read turnaround. The second isolates the derived read-to-write spacing. Random streams under several timing sets mix types and idle cycles, with the write latency set both below and above the read latency. That separates the case where the programmed turnaround dominates from the case where the bubble formula dominates. Throughout, the data strobes are matched against issue history and checked for bus overlap and bubble size.

// File: rtl/col_sched_pkg.sv
package col_sched_pkg;

   typedef enum logic {
      CMD_RD = 1'b0,
      CMD_WR = 1'b1
   } col_cmd_e;

   localparam int unsigned N_CMD_TYPES = 2;

endpackage

// File: rtl/col_gap_calc.sv
// Derives the effective cross-type spacings from the timing inputs.
module col_gap_calc #(
   parameter int TW = 6,
   parameter int CW = TW + 2
) (
   input  logic [TW-1:0] cfg_cc,
   input  logic [TW-1:0] cfg_wr_rd,
   input  logic [TW-1:0] cfg_rd_wr,
   input  logic [TW-1:0] cfg_wr_lat,
   input  logic [TW-1:0] cfg_rd_lat,
   input  logic [TW-1:0] cfg_wr_bub,
   input  logic [TW-1:0] cfg_rd_bub,
   output logic [CW-1:0] gap_w2r,
   output logic [CW-1:0] gap_r2w
);

   localparam int SW = CW + 1;

   logic signed [SW-1:0] w2r_form, r2w_form;
   logic [TW-1:0]        w2r_floor, r2w_floor;

   // bubble-derived values may be negative when one latency dominates
   always_comb begin
      w2r_form = $signed({3'b000, cfg_wr_bub}) + $signed({3'b000, cfg_cc})
               + $signed({3'b000, cfg_wr_lat}) - $signed({3'b000, cfg_rd_lat});
      r2w_form = $signed({3'b000, cfg_rd_lat}) - $signed({3'b000, cfg_wr_lat})
               + $signed({3'b000, cfg_cc}) + $signed({3'b000, cfg_rd_bub});
   end

   assign w2r_floor = (cfg_wr_rd > cfg_cc) ? cfg_wr_rd : cfg_cc;
   assign r2w_floor = (cfg_rd_wr > cfg_cc) ? cfg_rd_wr : cfg_cc;

   assign gap_w2r = (w2r_form > $signed({3'b000, w2r_floor})) ?
                    w2r_form[CW-1:0] : {2'b00, w2r_floor};
   assign gap_r2w = (r2w_form > $signed({3'b000, r2w_floor})) ?
                    r2w_form[CW-1:0] : {2'b00, r2w_floor};

endmodule

// File: rtl/col_wait_ctr.sv
// Saturating down-counter: zero means the guarded command type may issue.
module col_wait_ctr #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_gap,
   output logic          clear
);

   localparam logic [CW-1:0] ONE = CW'(1);

   logic [CW-1:0] cnt_q, dec, lval, cnt_d;

   always_comb begin
      dec   = (cnt_q == '0) ? '0 : cnt_q - ONE;
      lval  = (load_gap == '0) ? '0 : load_gap - ONE;
      cnt_d = (load && (lval > dec)) ? lval : dec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign clear = (cnt_q == '0);

endmodule

// File: rtl/col_data_pipe.sv
// Delay line turning an issue pulse into a strobe DELAY cycles later.
module col_data_pipe #(
   parameter int TW    = 6,
   parameter int DEPTH = 63
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ins,
   input  logic [TW-1:0] delay,
   output logic          strobe
);

   logic [DEPTH-1:0] pipe_q, pipe_d;

   always_comb begin
      pipe_d = pipe_q >> 1;
      for (int i = 0; i < DEPTH; i++) begin
         if (ins && (delay == TW'(i + 1))) pipe_d[i] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= pipe_d;
   end

   assign strobe = pipe_q[0];

endmodule

// File: rtl/col_sched.sv
module col_sched
   import col_sched_pkg::*;
#(
   parameter int TW      = 6,
   parameter int BANK_W  = 3,
   parameter int DLY_MAX = 63
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TW-1:0]     cfg_cc,
   input  logic [TW-1:0]     cfg_wr_rd,
   input  logic [TW-1:0]     cfg_rd_wr,
   input  logic [TW-1:0]     cfg_wr_lat,
   input  logic [TW-1:0]     cfg_rd_lat,
   input  logic [TW-1:0]     cfg_wr_bub,
   input  logic [TW-1:0]     cfg_rd_bub,
   input  logic              req_valid,
   input  logic              req_wr,
   input  logic [BANK_W-1:0] req_bank,
   output logic              req_ready,
   output logic              iss_valid,
   output logic              iss_wr,
   output logic [BANK_W-1:0] iss_bank,
   output logic              wdata_launch,
   output logic              rdata_valid
);

   localparam int CW = TW + 2;

   if (TW < 2) begin : g_bad_tw
      $error("col_sched: TW must be at least 2");
   end
   if (BANK_W < 1) begin : g_bad_bank
      $error("col_sched: BANK_W must be at least 1");
   end
   if ((DLY_MAX < 2) || (DLY_MAX > (1 << TW) - 1)) begin : g_bad_dly
      $error("col_sched: DLY_MAX must lie in 2..2**TW-1");
   end

   col_cmd_e      cmd;
   logic          fire;
   logic [CW-1:0] gap_w2r, gap_r2w;

   // index 0 guards/serves reads, index 1 writes
   logic [CW-1:0] cross_gap [N_CMD_TYPES];
   logic [CW-1:0] load_gap  [N_CMD_TYPES];
   logic [TW-1:0] lat       [N_CMD_TYPES];
   logic [N_CMD_TYPES-1:0] may_go, strobe;

   assign cmd = col_cmd_e'(req_wr);

   col_gap_calc #(.TW(TW), .CW(CW)) u_gap (
      .cfg_cc     (cfg_cc),
      .cfg_wr_rd  (cfg_wr_rd),
      .cfg_rd_wr  (cfg_rd_wr),
      .cfg_wr_lat (cfg_wr_lat),
      .cfg_rd_lat (cfg_rd_lat),
      .cfg_wr_bub (cfg_wr_bub),
      .cfg_rd_bub (cfg_rd_bub),
      .gap_w2r    (gap_w2r),
      .gap_r2w    (gap_r2w)
   );

   assign cross_gap[0] = gap_w2r;
   assign cross_gap[1] = gap_r2w;
   assign lat[0]       = cfg_rd_lat;
   assign lat[1]       = cfg_wr_lat;

   for (genvar k = 0; k < N_CMD_TYPES; k++) begin : g_type
      // same type reloads with the column spacing, the other type with its turnaround
      assign load_gap[k] = (req_wr == 1'(k)) ? {2'b00, cfg_cc} : cross_gap[k];

      col_wait_ctr #(.CW(CW)) u_wait (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (fire),
         .load_gap (load_gap[k]),
         .clear    (may_go[k])
      );

      col_data_pipe #(.TW(TW), .DEPTH(DLY_MAX)) u_pipe (
         .clk    (clk),
         .rst_n  (rst_n),
         .ins    (fire && (req_wr == 1'(k))),
         .delay  (lat[k]),
         .strobe (strobe[k])
      );
   end

   assign req_ready    = (cmd == CMD_WR) ? may_go[1] : may_go[0];
   assign fire         = req_valid && req_ready;
   assign iss_valid    = fire;
   assign iss_wr       = req_wr;
   assign iss_bank     = req_bank;
   assign rdata_valid  = strobe[0];
   assign wdata_launch = strobe[1];

endmodule

// File: rtl/col_sched_chk.sv
module col_sched_chk #(
   parameter int TW = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic [TW-1:0] cfg_cc,
   input logic [TW-1:0] cfg_wr_rd,
   input logic [TW-1:0] cfg_rd_wr,
   input logic [TW-1:0] cfg_wr_lat,
   input logic [TW-1:0] cfg_rd_lat,
   input logic [TW-1:0] cfg_wr_bub,
   input logic [TW-1:0] cfg_rd_bub,
   input logic          iss_valid,
   input logic          iss_wr,
   input logic          wdata_launch,
   input logic          rdata_valid
);

   localparam int CW = TW + 2;

   logic [CW-1:0] since_w, since_r;
   logic          any_iss;
   int            g_w2r, g_r2w, cc_i;

   always_comb begin
      cc_i  = int'(cfg_cc);
      g_w2r = int'(cfg_wr_bub) + cc_i + int'(cfg_wr_lat) - int'(cfg_rd_lat);
      if (int'(cfg_wr_rd) > g_w2r) g_w2r = int'(cfg_wr_rd);
      if (cc_i > g_w2r)            g_w2r = cc_i;
      g_r2w = int'(cfg_rd_lat) - int'(cfg_wr_lat) + cc_i + int'(cfg_rd_bub);
      if (int'(cfg_rd_wr) > g_r2w) g_r2w = int'(cfg_rd_wr);
      if (cc_i > g_r2w)            g_r2w = cc_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_w <= '1;
         since_r <= '1;
         any_iss <= 1'b0;
      end else begin
         since_w <= (iss_valid && iss_wr)  ? CW'(1) : ((since_w == '1) ? since_w : since_w + CW'(1));
         since_r <= (iss_valid && !iss_wr) ? CW'(1) : ((since_r == '1) ? since_r : since_r + CW'(1));
         any_iss <= any_iss || iss_valid;
      end
   end

   a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
      !any_iss |-> (!wdata_launch && !rdata_valid));

   a_r2_wr_to_rd: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !iss_wr) |-> (int'(since_w) >= g_w2r));

   a_r3_rd_to_wr: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_wr) |-> (int'(since_r) >= g_r2w));

   a_r4_wr_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_wr) |-> (int'(since_w) >= cc_i));

   a_r4_rd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !iss_wr) |-> (int'(since_r) >= cc_i));

   a_r5_launch_after_write: assert property (@(posedge clk) disable iff (!rst_n)
      wdata_launch |-> (int'(since_w) <= int'(cfg_wr_lat)));

   a_r6_return_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_valid |-> (int'(since_r) <= int'(cfg_rd_lat)));

endmodule

bind col_sched col_sched_chk #(.TW(TW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_cc       (cfg_cc),
   .cfg_wr_rd    (cfg_wr_rd),
   .cfg_rd_wr    (cfg_rd_wr),
   .cfg_wr_lat   (cfg_wr_lat),
   .cfg_rd_lat   (cfg_rd_lat),
   .cfg_wr_bub   (cfg_wr_bub),
   .cfg_rd_bub   (cfg_rd_bub),
   .iss_valid    (iss_valid),
   .iss_wr       (iss_wr),
   .wdata_launch (wdata_launch),
   .rdata_valid  (rdata_valid)
);

// File: tb/col_sched_tb_top.sv
module col_sched_tb_top;

   localparam int TW     = 6;
   localparam int BANK_W = 3;
   localparam int BIG    = 100000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [TW-1:0]     cfg_cc, cfg_wr_rd, cfg_rd_wr, cfg_wr_lat, cfg_rd_lat, cfg_wr_bub, cfg_rd_bub;
   logic              req_valid = 1'b0, req_wr = 1'b0;
   logic [BANK_W-1:0] req_bank = '0;
   logic              req_ready, iss_valid, iss_wr, wdata_launch, rdata_valid;
   logic [BANK_W-1:0] iss_bank;

   always #5 clk = ~clk;

   col_sched #(.TW(TW), .BANK_W(BANK_W), .DLY_MAX(63)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_cc(cfg_cc), .cfg_wr_rd(cfg_wr_rd), .cfg_rd_wr(cfg_rd_wr),
      .cfg_wr_lat(cfg_wr_lat), .cfg_rd_lat(cfg_rd_lat),
      .cfg_wr_bub(cfg_wr_bub), .cfg_rd_bub(cfg_rd_bub),
      .req_valid(req_valid), .req_wr(req_wr), .req_bank(req_bank),
      .req_ready(req_ready), .iss_valid(iss_valid), .iss_wr(iss_wr),
      .iss_bank(iss_bank), .wdata_launch(wdata_launch), .rdata_valid(rdata_valid)
   );

   int errors = 0, checks = 0;
   int cc, twr, trw, cwd, cac, wbub, rbub;
   int n = 0, since_w = BIG, since_r = BIG;
   int last_wd = -BIG, last_rd = -BIG;
   bit whist [256];
   bit rhist [256];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
   function automatic int gap_w2r();
      return mx(mx(twr, wbub + cc + cwd - cac), cc);
   endfunction
   function automatic int gap_r2w();
      return mx(mx(trw, cac - cwd + cc + rbub), cc);
   endfunction

   task automatic set_cfg(input int c, input int w2r, input int r2w, input int wl,
                          input int rl, input int wb, input int rb);
      cc = c; twr = w2r; trw = r2w; cwd = wl; cac = rl; wbub = wb; rbub = rb;
      cfg_cc = TW'(c); cfg_wr_rd = TW'(w2r); cfg_rd_wr = TW'(r2w);
      cfg_wr_lat = TW'(wl); cfg_rd_lat = TW'(rl);
      cfg_wr_bub = TW'(wb); cfg_rd_bub = TW'(rb);
   endtask

   // one clock cycle: drive at negedge, compare against the model, update the model
   task automatic step(input bit v, input bit w, input int b, output bit fired);
      bit er, ewl, erv, iw, ir;
      @(negedge clk);
      req_valid = v; req_wr = w; req_bank = BANK_W'(b);
      #1;
      er = w ? (since_w >= cc && since_r >= gap_r2w())
             : (since_r >= cc && since_w >= gap_w2r());
      chk(req_ready === er, "R8 ready", int'(req_ready), int'(er));
      chk(iss_valid === (v && er), "R7 iss_valid", int'(iss_valid), int'(v && er));
      iw = iss_valid && iss_wr;
      ir = iss_valid && !iss_wr;
      if (iss_valid) begin
         chk(iss_wr === w, "R7 iss_wr", int'(iss_wr), int'(w));
         chk(iss_bank === BANK_W'(b), "R7 iss_bank", int'(iss_bank), b);
      end
      if (ir) begin
         chk(since_w >= gap_w2r(), "R2 write-to-read spacing", since_w, gap_w2r());
         chk(since_r >= cc, "R4 read spacing", since_r, cc);
      end
      if (iw) begin
         chk(since_r >= gap_r2w(), "R3 read-to-write spacing", since_r, gap_r2w());
         chk(since_w >= cc, "R4 write spacing", since_w, cc);
      end
      ewl = (n >= cwd) && whist[(n - cwd) % 256];
      erv = (n >= cac) && rhist[(n - cac) % 256];
      chk(wdata_launch === ewl, "R5 write data launch", int'(wdata_launch), int'(ewl));
      chk(rdata_valid === erv, "R6 read data valid", int'(rdata_valid), int'(erv));
      if (wdata_launch) begin
         chk(n - last_wd >= cc, "R10 write packet overlap", n - last_wd, cc);
         chk(n - (last_rd + cc) >= rbub, "R10 read-to-write bubble", n - (last_rd + cc), rbub);
         last_wd = n;
      end
      if (rdata_valid) begin
         chk(n - last_rd >= cc, "R10 read packet overlap", n - last_rd, cc);
         chk(n - (last_wd + cc) >= wbub, "R10 write-to-read bubble", n - (last_wd + cc), wbub);
         last_rd = n;
      end
      whist[n % 256] = iw;
      rhist[n % 256] = ir;
      since_w = iw ? 1 : ((since_w < BIG) ? since_w + 1 : BIG);
      since_r = ir ? 1 : ((since_r < BIG) ? since_r + 1 : BIG);
      fired = iss_valid;
      n++;
   endtask

   task automatic idle(input int cyc);
      bit f;
      for (int i = 0; i < cyc; i++) step(1'b0, 1'b0, 0, f);
   endtask

   task automatic rand_run(input int cyc);
      bit f;
      for (int i = 0; i < cyc; i++)
         step(($urandom % 10) < 8, $urandom % 2, $urandom % 8, f);
   endtask

   task automatic run_seq(input bit k0, input bit k1, input bit k2,
                          input int b0, input int b1, input int b2,
                          output int c0, output int c1, output int c2);
      bit f;
      f = 0; while (!f) step(1'b1, k0, b0, f); c0 = n - 1;
      f = 0; while (!f) step(1'b1, k1, b1, f); c1 = n - 1;
      f = 0; while (!f) step(1'b1, k2, b2, f); c2 = n - 1;
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      finish_run();
   end

   initial begin
      int c0, c1, c2;
      void'($urandom(32'd2024));
      // nominal set: w2r gap 9 (programmed), r2w gap 6 (bubble formula)
      set_cfg(2, 9, 0, 3, 6, 2, 1);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      @(negedge clk);
      req_wr = 1'b0; #1;
      chk(req_ready === 1'b1, "R1 read ready after reset", int'(req_ready), 1);
      req_wr = 1'b1; #1;
      chk(req_ready === 1'b1, "R1 write ready after reset", int'(req_ready), 1);
      chk(!wdata_launch && !rdata_valid, "R1 no strobe after reset",
          int'(wdata_launch) + int'(rdata_valid), 0);
      idle(4);

      // write, write, read on another bank
      run_seq(1'b1, 1'b1, 1'b0, 0, 0, 5, c0, c1, c2);
      chk(c1 - c0 == 2, "R4 write-write spacing", c1 - c0, 2);
      chk(c2 - c1 == 9, "R9 cross-bank write-to-read", c2 - c1, 9);
      idle(70);
      // read, read, write
      run_seq(1'b0, 1'b0, 1'b1, 3, 3, 3, c0, c1, c2);
      chk(c1 - c0 == 2, "R4 read-read spacing", c1 - c0, 2);
      chk(c2 - c1 == 6, "R3 derived read-to-write", c2 - c1, 6);
      idle(70);
      rand_run(600);
      idle(70);

      // write latency above read latency: w2r from bubble formula (4), r2w floored at cc
      set_cfg(1, 1, 1, 5, 2, 0, 0);
      run_seq(1'b1, 1'b1, 1'b0, 1, 2, 7, c0, c1, c2);
      chk(c1 - c0 == 1, "R4 back-to-back writes", c1 - c0, 1);
      chk(c2 - c1 == 4, "R2 formula write-to-read", c2 - c1, 4);
      idle(70);
      run_seq(1'b0, 1'b0, 1'b1, 4, 4, 0, c0, c1, c2);
      chk(c2 - c1 == 1, "R3 floor read-to-write", c2 - c1, 1);
      idle(70);
      rand_run(600);
      idle(70);

      for (int s = 0; s < 6; s++) begin
         set_cfg(1 + $urandom % 4, $urandom % 12, $urandom % 12,
                 1 + $urandom % 20, 1 + $urandom % 20, $urandom % 5, $urandom % 5);
         rand_run(500);
         idle(70);
      end
      finish_run();
   end

endmodule